// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block conditions a single external interrupt pin for a small microcontroller. The pin first passes through a two-flop synchronizer. A sampled noise canceller follows, and its output moves to a new level only after that level has been seen on three consecutive sample strobes. The sample strobe is taken from a gear-clock enable divided by 1, 4, 8 or 16 in the fast power modes. In the slow and sleep modes it is taken from a low-frequency clock enable divided by 4.

An edge of the selected polarity on the filtered signal sets a sticky interrupt request. Software clears this request with a one-cycle pulse. An 8-bit control byte selects the trigger edge and the sampling interval. The same byte also reports the filtered level that was captured when the last request fired. Changing the control byte or the power mode can disturb the filter, so software is expected to clear the request after such a change. Interrupt enabling, priority, vectoring and clock generation are outside this block.

Top module: `pinEdgeIrq`

## Requirements
- R1: After reset the control byte reads 0x00 and the interrupt request output is low.
- R2: Control byte layout: bits 1:0 select the sampling interval, bits 3:2 select the edge, and bit 4 is the read-only level snapshot. Bits 7:5 always read 0. Written values for bits 7:4 have no effect.
- R3: The pin is synchronized through two flops. The filtered level changes only after three consecutive sample strobes have seen the new synchronized level. With interval code 00 and the gear strobe high every cycle, a pin change held for at least three cycles raises the request on the 5th rising clock edge after the change. A pulse of two cycles produces no request.
- R4: Edge code 00 triggers on a rising filtered edge, 01 on a falling edge and 10 on both edges. Code 11 never raises a request.
- R5: In fast mode (slowMode=0), interval codes 00, 01, 10 and 11 give one filter sample every 1, 4, 8 and 16 gear strobes respectively.
- R6: In slow mode (slowMode=1), the filter samples once every 4 low-frequency strobes, whatever the interval code.
- R7: When a request fires, bit 4 captures the new filtered level: 1 for a rising edge and 0 for a falling edge.
- R8: The request stays high until an irqClear pulse. The clear takes effect at the next clock edge. If a clear and a new edge arrive in the same cycle, the request stays set.
- R9: The filtered signal resets low. A pin held high through reset therefore produces exactly one rising-edge request once the filter settles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 1 | Raw external interrupt pin |
| gearTick | input | 1 | One-cycle enable strobe at the gear-clock rate |
| slowTick | input | 1 | One-cycle enable strobe at the low-frequency clock rate |
| slowMode | input | 1 | 1 selects the slow or sleep sampling source |
| regWrEn | input | 1 | Write strobe for the control byte |
| regWrData | input | 8 | Write data for the control byte |
| regRdData | output | 8 | Current control byte contents |
| irqClear | input | 1 | One-cycle pulse that clears the request |
| irqReq | output | 1 | Latched interrupt request |

## Verification
The assertions assume the following about the inputs. gearTick and slowTick are plain one-cycle enables, and each sample strobe comes from the strobe that belongs to the active mode. irqClear is a pulse, and the control byte changes only through regWrEn. They make no assumption about the pin, which may toggle at any time.

The stimulus stays within these assumptions in three ways:
- It holds both strobes high every cycle, or keeps them as regular single-cycle pulses.
- It changes slowMode or the edge code only while the filter is settled, and it clears the request afterwards.
- Where the divider phase cannot be seen at the ports, it checks request latency against a window instead of an exact cycle.

// File: rtl/pinEdgeIrqPkg.sv
package pinEdgeIrqPkg;

  // Edge trigger selection; code values match the control byte field.
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edgeSel_e;

  // Software-visible configuration held by the control module.
  typedef struct packed {
    edgeSel_e   edgeSel;
    logic [1:0] interval;
  } cfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic sample;
    logic armRise;
    logic armFall;
  } ctrlStb_t;

endpackage

// File: rtl/pinEdgeIrqCtrl.sv
module pinEdgeIrqCtrl
  import pinEdgeIrqPkg::*;
#(
  parameter int SHIFT_A  = 2,
  parameter int SHIFT_B  = 3,
  parameter int SHIFT_C  = 4,
  parameter int SLOW_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gearTick,
  input  logic       slowTick,
  input  logic       slowMode,
  input  logic       regWrEn,
  input  logic [3:0] cfgWrData,
  output cfg_t       cfg,
  output ctrlStb_t   stb
);

  localparam int GW = SHIFT_C;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  // Configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfg <= '0;
    else if (regWrEn) cfg <= cfg_t'(cfgWrData);
  end

  // Fast-mode divider: sample when the masked phase bits are all ones
  logic [GW-1:0] gearPhase;
  logic [31:0]   maskWide;
  logic [GW-1:0] gearMask;
  logic          gearHit;
  int unsigned   shiftSel;

  always_comb begin
    case (cfg.interval)
      2'd0:    shiftSel = 0;
      2'd1:    shiftSel = SHIFT_A;
      2'd2:    shiftSel = SHIFT_B;
      default: shiftSel = SHIFT_C;
    endcase
    maskWide = (32'd1 << shiftSel) - 32'd1;
    gearMask = maskWide[GW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         gearPhase <= '0;
    else if (gearTick) gearPhase <= gearPhase + 1'b1;
  end

  assign gearHit = gearTick && ((gearPhase & gearMask) == gearMask);

  // Slow-mode divider
  logic slowHit;
  generate
    if (SLOW_DIV > 1) begin : gSlowDiv
      logic [SW-1:0] slowPhase;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) slowPhase <= '0;
        else if (slowTick) begin
          if (slowPhase == SW'(SLOW_DIV - 1)) slowPhase <= '0;
          else                                slowPhase <= slowPhase + 1'b1;
        end
      end
      assign slowHit = slowTick && (slowPhase == SW'(SLOW_DIV - 1));
    end else begin : gSlowDirect
      assign slowHit = slowTick;
    end
  endgenerate

  always_comb begin
    stb.sample  = slowMode ? slowHit : gearHit;
    stb.armRise = (cfg.edgeSel == EDGE_RISE) || (cfg.edgeSel == EDGE_BOTH);
    stb.armFall = (cfg.edgeSel == EDGE_FALL) || (cfg.edgeSel == EDGE_BOTH);
  end

  // R5: a fast-mode sample needs a gear strobe
  a_r5_fast_needs_gear: assert property (@(posedge clk) disable iff (!rstN)
    (!slowMode && stb.sample) |-> gearTick);
  // R5: interval code 00 samples on every gear strobe
  a_r5_full_rate: assert property (@(posedge clk) disable iff (!rstN)
    (!slowMode && cfg.interval == 2'd0 && gearTick) |-> stb.sample);
  // R6: a slow-mode sample needs a low-frequency strobe
  a_r6_slow_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (slowMode && stb.sample) |-> slowTick);
  // R2: configuration changes only on a write
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(cfg));

endmodule

// File: rtl/pinEdgeIrqData.sv
module pinEdgeIrqData
  import pinEdgeIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_MATCH  = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pinIn,
  input  ctrlStb_t stb,
  input  logic     irqClear,
  output logic     irqReq,
  output logic     levelSnap,
  output logic     edgeFire
);

  localparam int RW = (FILT_MATCH > 1) ? $clog2(FILT_MATCH) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(FILT_MATCH - 1);

  // Synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end
  assign syncIn = syncChain[SYNC_STAGES-1];

  // Noise canceller: count consecutive mismatching samples
  logic          filtLevel;
  logic [RW-1:0] runCnt;
  logic          mismatch;
  logic          flip;

  assign mismatch = (syncIn != filtLevel);
  assign flip     = stb.sample && mismatch && (runCnt == RUN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLevel <= 1'b0;
      runCnt    <= '0;
    end else if (stb.sample) begin
      if (!mismatch || flip) runCnt <= '0;
      else                   runCnt <= runCnt + 1'b1;
      if (flip) filtLevel <= syncIn;
    end
  end

  // Edge detection and request latch (set has priority over clear)
  assign edgeFire = (flip && syncIn && stb.armRise) || (flip && !syncIn && stb.armFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      levelSnap <= 1'b0;
    end else begin
      if (edgeFire)      irqReq <= 1'b1;
      else if (irqClear) irqReq <= 1'b0;
      if (edgeFire)      levelSnap <= syncIn;
    end
  end

  // R3: filter holds between sample strobes
  a_r3_quiet_between_samples: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sample |=> $stable(filtLevel));
  // R8: request is sticky without a clear
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqClear) |=> irqReq);
  // R8: an edge sets the request even with a clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    edgeFire |=> irqReq);
  // R8: a clear without an edge drops the request
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !edgeFire) |=> !irqReq);
  // R4: nothing is armed, so no new request
  a_r4_unarmed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && !stb.armRise && !stb.armFall) |=> !irqReq);
  // R7: snapshot equals the filtered level after a request fires
  a_r7_snap_level: assert property (@(posedge clk) disable iff (!rstN)
    edgeFire |=> (levelSnap == filtLevel));

endmodule

// File: rtl/pinEdgeIrq.sv
module pinEdgeIrq
  import pinEdgeIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_MATCH  = 3,
  parameter int SHIFT_A     = 2,
  parameter int SHIFT_B     = 3,
  parameter int SHIFT_C     = 4,
  parameter int SLOW_DIV    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       gearTick,
  input  logic       slowTick,
  input  logic       slowMode,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       irqClear,
  output logic       irqReq
);

  cfg_t     cfg;
  ctrlStb_t stb;
  logic     levelSnap;
  logic     edgeFire;

  pinEdgeIrqCtrl #(
    .SHIFT_A (SHIFT_A),
    .SHIFT_B (SHIFT_B),
    .SHIFT_C (SHIFT_C),
    .SLOW_DIV(SLOW_DIV)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .gearTick (gearTick),
    .slowTick (slowTick),
    .slowMode (slowMode),
    .regWrEn  (regWrEn),
    .cfgWrData(regWrData[3:0]),
    .cfg      (cfg),
    .stb      (stb)
  );

  pinEdgeIrqData #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_MATCH (FILT_MATCH)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .stb      (stb),
    .irqClear (irqClear),
    .irqReq   (irqReq),
    .levelSnap(levelSnap),
    .edgeFire (edgeFire)
  );

  assign regRdData = {3'b000, levelSnap, cfg.edgeSel, cfg.interval};

  // R2: writes to the unimplemented bits never show up
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regWrData[7:5] != 3'b000)) |=> (regRdData[7:5] == 3'b000));
  // R2: writing bit 4 does not change the snapshot
  a_r2_level_not_written: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !edgeFire && (regWrData[4] != regRdData[4])) |=> $stable(regRdData[4]));

endmodule

// File: tb/pinEdgeIrq_test.sv
module pinEdgeIrq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinIn = 1'b1;
  logic       gearTick = 1'b1;
  logic       slowTick = 1'b1;
  logic       slowMode = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       irqClear = 1'b0;
  logic       irqReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pinEdgeIrq uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .gearTick(gearTick),
    .slowTick(slowTick), .slowMode(slowMode), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqClear(irqClear),
    .irqReq(irqReq)
  );

  // Advance n rising edges and settle 1 ns past the last one
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkRange(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWrData = d;
    regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic clearIrq();
    irqClear = 1'b1;
    tick(1);
    irqClear = 1'b0;
  endtask

  // Cycles from now until irqReq rises, capped at limit
  task automatic measureFire(input int limit, output int cyc);
    cyc = 0;
    while (!irqReq && cyc < limit) begin
      tick(1);
      cyc++;
    end
  endtask

  task automatic testReset();
    tick(3);
    rstN = 1'b1;
    check("R1 reset reg", int'(regRdData), 0);
    check("R1 reset irq", int'(irqReq), 0);
    tick(4);
    check("R9 no irq before settle", int'(irqReq), 0);
    tick(1);
    check("R9 rise after reset", int'(irqReq), 1);
    check("R7 level snap high", int'(regRdData[4]), 1);
    clearIrq();
    check("R8 clear drops", int'(irqReq), 0);
    tick(30);
    check("R9 single request", int'(irqReq), 0);
  endtask

  task automatic testRegLayout();
    writeReg(8'hFB);
    check("R2 masked readback", int'(regRdData), 8'h1B);
    writeReg(8'h00);
    check("R2 level kept", int'(regRdData), 8'h10);
  endtask

  task automatic testEdgeModes();
    // R4 falling mode, exact timing per R3
    writeReg(8'h04);
    pinIn = 1'b0;
    tick(4);
    check("R3 not yet at edge 4", int'(irqReq), 0);
    tick(1);
    check("R4 fall fires at edge 5", int'(irqReq), 1);
    check("R7 level snap low", int'(regRdData[4]), 0);
    clearIrq();
    pinIn = 1'b1;
    tick(10);
    check("R4 fall mode ignores rise", int'(irqReq), 0);
    // R4 reserved code 11
    writeReg(8'h0C);
    pinIn = 1'b0;
    tick(10);
    check("R4 reserved no fall", int'(irqReq), 0);
    pinIn = 1'b1;
    tick(10);
    check("R4 reserved no rise", int'(irqReq), 0);
    // R4 both edges
    writeReg(8'h08);
    pinIn = 1'b0;
    tick(5);
    check("R4 both fires on fall", int'(irqReq), 1);
    clearIrq();
    pinIn = 1'b1;
    tick(5);
    check("R4 both fires on rise", int'(irqReq), 1);
    check("R7 snap after rise", int'(regRdData[4]), 1);
    clearIrq();
    // R4 rising mode ignores fall
    writeReg(8'h00);
    pinIn = 1'b0;
    tick(10);
    check("R4 rise mode ignores fall", int'(irqReq), 0);
    pinIn = 1'b1;
    tick(10);
    clearIrq();
  endtask

  task automatic testGlitch();
    writeReg(8'h08);   // both edges, interval 00
    pinIn = 1'b0;
    tick(2);
    pinIn = 1'b1;
    tick(10);
    check("R3 two-cycle glitch rejected", int'(irqReq), 0);
    pinIn = 1'b0;
    tick(3);
    pinIn = 1'b1;
    tick(2);
    check("R3 three-cycle pulse accepted", int'(irqReq), 1);
    check("R7 snap low on pulse", int'(regRdData[4]), 0);
    tick(10);
    clearIrq();
    writeReg(8'h00);
  endtask

  task automatic runInterval(input logic [1:0] code, input int lo, input int hi, input string tag);
    int cyc;
    writeReg({6'b0, code});
    pinIn = 1'b0;
    tick(70);
    clearIrq();
    check({tag, " idle"}, int'(irqReq), 0);
    pinIn = 1'b1;
    measureFire(100, cyc);
    checkRange(tag, cyc, lo, hi);
    clearIrq();
  endtask

  task automatic testIntervals();
    runInterval(2'd0, 5, 5, "R5 interval 1");
    runInterval(2'd1, 11, 14, "R5 interval 4");
    runInterval(2'd2, 19, 26, "R5 interval 8");
    runInterval(2'd3, 35, 50, "R5 interval 16");
  endtask

  task automatic testSlow();
    slowMode = 1'b1;
    runInterval(2'd3, 11, 14, "R6 slow divide 4");
    gearTick = 1'b0;
    runInterval(2'd0, 11, 14, "R6 slow ignores gear");
    gearTick = 1'b1;
    slowMode = 1'b0;
    writeReg(8'h00);
  endtask

  task automatic testClearPriority();
    // Leave a request pending, re-arm the filter low, then collide clear with an edge
    pinIn = 1'b0;
    tick(10);
    clearIrq();
    pinIn = 1'b1;
    tick(5);
    check("R8 pending request", int'(irqReq), 1);
    pinIn = 1'b0;
    tick(10);
    pinIn = 1'b1;
    tick(4);
    irqClear = 1'b1;
    tick(1);
    irqClear = 1'b0;
    check("R8 set wins over clear", int'(irqReq), 1);
    tick(20);
    check("R8 stays set", int'(irqReq), 1);
    clearIrq();
    check("R8 clear after hold", int'(irqReq), 0);
  endtask

  initial begin
    testReset();
    testRegLayout();
    testEdgeModes();
    testGlitch();
    testIntervals();
    testSlow();
    testClearPriority();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule